// File: doc/BRIEF.md
# Partitioned Subword SIMD Adder

This block adds two 64-bit packed operands using eight 8-bit adder segments that all work within the same operation. A 2-bit width select decides where the carry chain is cut. The same segments therefore serve as one 64-bit adder, two 32-bit lanes, four 16-bit lanes or eight 8-bit lanes. No adder hardware is duplicated between the packing modes.

Inside a lane, each segment's carry-out feeds the next segment up. At a lane boundary the carry into the upper segment is forced to zero. Each lane's carry-out appears on an 8-bit vector, at the bit index of that lane's top segment.

The sum and carry vector pass through an output register by default. A result therefore appears one clock after its operands, and a new operation can start every cycle.

Top module: `psimd_adder`

## Requirements
- R1: Bits 7:0 of the sum always equal (a[7:0] + b[7:0]) mod 256 in every mode, because the carry into the lowest segment is always zero.
- R2: With width select 00, the result holds eight independent 8-bit lanes. Lane k occupies bits 8k+7:8k, and its carry-out is on carry bit k.
- R3: With width select 01, the result holds four 16-bit lanes. Lane k occupies bits 16k+15:16k, and its carry-out is on carry bit 2k+1.
- R4: With width select 10, the result holds two 32-bit lanes. Lane k occupies bits 32k+31:32k, and its carry-out is on carry bit 4k+3.
- R5: With width select 11, the result is a single 64-bit sum, and its carry-out is on carry bit 7.
- R6: Every carry bit that is not at the top segment of a lane in the current mode reads 0.
- R7: No carry crosses a lane boundary. When every lane computes all-ones plus one, every lane reads zero and each lane reports a carry-out of 1.
- R8: The sum and carry vector for operands presented before a rising clock edge appear after that edge. A new operation is accepted on every cycle.
- R9: A synchronous active-high reset clears the sum and the carry vector to zero, whatever the operands are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| width_sel_i | input | 2 | Lane width: 00 = 8-bit, 01 = 16-bit, 10 = 32-bit, 11 = 64-bit |
| op_a_i | input | 64 | First packed operand |
| op_b_i | input | 64 | Second packed operand |
| sum_o | output | 64 | Packed lane sums |
| carry_o | output | 8 | Lane carry-outs, one at each lane's top segment index |

## Verification
Random operand pairs are applied in all four widths. These patterns separate correct lane arithmetic from a wrong cut position: such a fault misplaces carries only on some operand values. Operands of all ones plus one in every lane are applied in each mode. They ripple a carry through the whole lane, so any boundary that leaks, or any intra-lane link that is cut, changes a neighbouring lane or drops the lane's carry. All-ones plus all-ones and zero operands check that the carry vector stays quiet at non-top positions. A reset asserted in the middle of the run checks that the registered outputs clear.

// File: rtl/psimd_adder_pkg.sv
package psimd_adder_pkg;
    localparam int SEG_W   = 8;
    localparam int NUM_SEG = 8;
    localparam int DATA_W  = SEG_W * NUM_SEG;
    localparam int SEL_W   = 2;

    typedef enum logic [SEL_W-1:0] {
        LANE_8  = 2'b00,
        LANE_16 = 2'b01,
        LANE_32 = 2'b10,
        LANE_64 = 2'b11
    } lane_width_e;

    typedef struct packed {
        logic [NUM_SEG-1:0] carry;
        logic [DATA_W-1:0]  sum;
    } add_result_t;

    // Number of segments spanned by one lane for a given width select.
    function automatic int lane_span(input logic [SEL_W-1:0] sel);
        int span;
        span = 1 << sel;
        if (span > NUM_SEG) span = NUM_SEG;
        return span;
    endfunction
endpackage

// File: rtl/seg_adder.sv
module seg_adder #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o
);
    logic [W:0] total;

    always_comb begin
        total  = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};
        sum_o  = total[W-1:0];
        cout_o = total[W];
    end
endmodule

// File: rtl/lane_boundary.sv
module lane_boundary
    import psimd_adder_pkg::*;
(
    input  logic [SEL_W-1:0]   sel_i,
    output logic [NUM_SEG-1:0] first_o,
    output logic [NUM_SEG-1:0] last_o
);
    int span;

    always_comb begin
        span = lane_span(sel_i);
        for (int i = 0; i < NUM_SEG; i++) begin
            first_o[i] = ((i % span) == 0);
            last_o[i]  = ((i % span) == (span - 1));
        end
    end
endmodule

// File: rtl/result_stage.sv
module result_stage
    import psimd_adder_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic        clk,
    input  logic        rst,
    input  add_result_t d_i,
    output add_result_t q_o
);
    generate
        if (REG_OUT) begin : g_reg
            add_result_t q_r;
            always_ff @(posedge clk) begin
                if (rst) q_r <= '0;
                else     q_r <= d_i;
            end
            assign q_o = q_r;
        end else begin : g_comb
            logic unused_ok;
            assign unused_ok = clk ^ rst;
            assign q_o = d_i;
        end
    endgenerate
endmodule

// File: rtl/psimd_adder.sv
module psimd_adder
    import psimd_adder_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SEL_W-1:0]  width_sel_i,
    input  logic [DATA_W-1:0] op_a_i,
    input  logic [DATA_W-1:0] op_b_i,
    output logic [DATA_W-1:0] sum_o,
    output logic [NUM_SEG-1:0] carry_o
);
    logic [NUM_SEG-1:0] seg_first;
    logic [NUM_SEG-1:0] seg_last;
    add_result_t        comb_res;
    add_result_t        out_res;

    lane_boundary u_bound (
        .sel_i   (width_sel_i),
        .first_o (seg_first),
        .last_o  (seg_last)
    );

    generate
        for (genvar i = 0; i < NUM_SEG; i++) begin : g_seg
            logic             ci;
            logic             co;
            logic [SEG_W-1:0] s;

            if (i == 0) begin : g_base
                assign ci = 1'b0;
            end else begin : g_link
                // Carry passes only when this segment continues a lane.
                assign ci = seg_first[i] ? 1'b0 : g_seg[i-1].co;
            end

            seg_adder #(.W(SEG_W)) u_add (
                .a_i    (op_a_i[i*SEG_W +: SEG_W]),
                .b_i    (op_b_i[i*SEG_W +: SEG_W]),
                .cin_i  (ci),
                .sum_o  (s),
                .cout_o (co)
            );

            assign comb_res.sum[i*SEG_W +: SEG_W] = s;
            assign comb_res.carry[i]              = seg_last[i] & co;
        end
    endgenerate

    result_stage #(.REG_OUT(REG_OUT)) u_out (
        .clk (clk),
        .rst (rst),
        .d_i (comb_res),
        .q_o (out_res)
    );

    assign sum_o   = out_res.sum;
    assign carry_o = out_res.carry;
endmodule

// File: rtl/psimd_adder_chk.sv
module psimd_adder_chk
    import psimd_adder_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [SEL_W-1:0]   width_sel_i,
    input  logic [DATA_W-1:0]  op_a_i,
    input  logic [DATA_W-1:0]  op_b_i,
    input  logic [DATA_W-1:0]  sum_o,
    input  logic [NUM_SEG-1:0] carry_o
);
    // Reset clears the outputs (R9)
    assert_reset_clear_R9: assert property (@(posedge clk)
        rst |=> (sum_o == '0 && carry_o == '0));

    // Lowest byte unaffected by mode, one-cycle latency (R1, R8)
    assert_low_byte_R1: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (sum_o[SEG_W-1:0] == $past(op_a_i[SEG_W-1:0] + op_b_i[SEG_W-1:0])));

    // Top 8-bit lane in byte mode (R2)
    assert_top_byte_lane_R2: assert property (@(posedge clk) disable iff (rst)
        (width_sel_i == LANE_8) |=>
        ({carry_o[NUM_SEG-1], sum_o[DATA_W-1 -: SEG_W]} ==
         $past({1'b0, op_a_i[DATA_W-1 -: SEG_W]} + {1'b0, op_b_i[DATA_W-1 -: SEG_W]})));

    // Full-width add (R5)
    assert_full_width_R5: assert property (@(posedge clk) disable iff (rst)
        (width_sel_i == LANE_64) |=>
        ({carry_o[NUM_SEG-1], sum_o} == $past({1'b0, op_a_i} + {1'b0, op_b_i})));

    // Carry positions outside lane tops stay 0 (R6)
    assert_carry_pos16_R6: assert property (@(posedge clk) disable iff (rst)
        (width_sel_i == LANE_16) |=> ((carry_o & 8'b0101_0101) == '0));
    assert_carry_pos32_R6: assert property (@(posedge clk) disable iff (rst)
        (width_sel_i == LANE_32) |=> ((carry_o & 8'b0111_0111) == '0));
    assert_carry_pos64_R6: assert property (@(posedge clk) disable iff (rst)
        (width_sel_i == LANE_64) |=> ($countones(carry_o[NUM_SEG-2:0]) == 0));
endmodule

bind psimd_adder psimd_adder_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .width_sel_i (width_sel_i),
    .op_a_i      (op_a_i),
    .op_b_i      (op_b_i),
    .sum_o       (sum_o),
    .carry_o     (carry_o)
);

// File: tb/psimd_adder_test.sv
module psimd_adder_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  width_sel = 2'b00;
    logic [63:0] op_a = '0;
    logic [63:0] op_b = '0;
    logic [63:0] sum;
    logic [7:0]  carry;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    logic [71:0] exp_q[$];
    string       tag_q[$];

    always #4 clk = ~clk;

    psimd_adder uut (
        .clk         (clk),
        .rst         (rst),
        .width_sel_i (width_sel),
        .op_a_i      (op_a),
        .op_b_i      (op_b),
        .sum_o       (sum),
        .carry_o     (carry)
    );

    // Behavioural reference: {carry, sum}
    function automatic logic [71:0] ref_add(input logic [1:0] sel,
                                            input logic [63:0] a,
                                            input logic [63:0] b);
        int          w;
        int          lanes;
        logic [64:0] mask;
        logic [64:0] x;
        logic [64:0] y;
        logic [64:0] s;
        logic [63:0] rs;
        logic [7:0]  rc;
        w     = 8 << sel;
        lanes = 64 / w;
        mask  = (65'd1 << w) - 65'd1;
        rs    = '0;
        rc    = '0;
        for (int l = 0; l < lanes; l++) begin
            x  = ({1'b0, a} >> (l * w)) & mask;
            y  = ({1'b0, b} >> (l * w)) & mask;
            s  = x + y;
            rs = rs | 64'((s & mask) << (l * w));
            rc[(l + 1) * (w / 8) - 1] = s[w];
        end
        return {rc, rs};
    endfunction

    // One cycle: check the previous result, then apply new inputs.
    task automatic step(input logic r, input logic [1:0] sel,
                        input logic [63:0] a, input logic [63:0] b,
                        input string tag);
        logic [71:0] e;
        string       t;
        @(negedge clk);
        if (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            total++;
            if ({carry, sum} !== e) begin
                bad++;
                $display("FAIL %s: got carry=%h sum=%h expected carry=%h sum=%h",
                         t, carry, sum, e[71:64], e[63:0]);
            end
        end
        rst       = r;
        width_sel = sel;
        op_a      = a;
        op_b      = b;
        exp_q.push_back(r ? 72'd0 : ref_add(sel, a, b));
        tag_q.push_back(tag);
    endtask

    function automatic string mode_tag(input logic [1:0] sel);
        case (sel)
            2'b00:   return "R1/R2/R6/R8";
            2'b01:   return "R1/R3/R6/R8";
            2'b10:   return "R1/R4/R6/R8";
            default: return "R1/R5/R6/R8";
        endcase
    endfunction

    initial begin
        logic [63:0] ones_lane;
        step(1'b1, 2'b11, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, "R9");
        step(1'b1, 2'b00, 64'h1234_5678_9ABC_DEF0, 64'hFFFF_0000_FFFF_0000, "R9");
        // Zero operands and all ones plus all ones, every mode
        for (int m = 0; m < 4; m++) begin
            step(1'b0, 2'(m), 64'd0, 64'd0, mode_tag(2'(m)));
            step(1'b0, 2'(m), '1, '1, mode_tag(2'(m)));
        end
        // All-ones plus one in every lane: R7
        for (int m = 0; m < 4; m++) begin
            ones_lane = '0;
            for (int l = 0; l < (8 >> m); l++)
                ones_lane[l * (8 << m)] = 1'b1;
            step(1'b0, 2'(m), '1, ones_lane, "R7");
            step(1'b0, 2'(m), ones_lane, '1, "R7");
        end
        // Random operands, back-to-back, mode changing every cycle: R8
        for (int i = 0; i < 400; i++) begin
            logic [1:0] s;
            s = 2'(i % 4);
            step(1'b0, s, {$urandom, $urandom}, {$urandom, $urandom}, mode_tag(s));
        end
        // Random operands per mode
        for (int m = 0; m < 4; m++)
            for (int i = 0; i < 150; i++)
                step(1'b0, 2'(m), {$urandom, $urandom}, {$urandom, $urandom}, mode_tag(2'(m)));
        // Mid-run reset: R9
        step(1'b1, 2'b11, '1, '1, "R9");
        step(1'b0, 2'b00, 64'h80FF_7F01_FE02_FF00, 64'h80FF_8101_0302_0100, "R2/R7");
        step(1'b0, 2'b00, 64'd0, 64'd0, "R2");
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule